// File: doc/BRIEF.md
# Audio Port Interrupt Status Unit

This block gathers the event indications of a serial audio port into one 16-bit status word and raises a single level interrupt. A configurable enable word masks that interrupt. Some status bits are live: they repeat level inputs from the transmit and receive paths, such as packet availability and receive FIFO fill. Other bits are sticky: a one-cycle event pulse sets them, and they stay set until software writes a one to the matching position of a write-only clear register.

Software uses a plain 32-bit register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The enable register sits at offset 0x10, status at 0x14 and clear at 0x18. A parameter chooses whether the interrupt line comes straight from the masking logic or through one register stage.

Top module: `aud_irq_status`

## Requirements
- R1: After reset, every sticky flag and every enable bit is zero, and the interrupt is low.
- R2: A high on `ev_pulse[k]` (k = 0..8) sets status bit k+3, and the bit stays set after the pulse ends. The mapping is: bit 3 end of transfer, bit 4 transfer filled, bit 5 underrun, bit 6 overrun, bit 7 CRC error, bit 8 frame error, bit 9 mode fault, bit 10 reload, bit 11 suspended.
- R3: A write to offset 0x18 clears each sticky status bit in 3..11 whose data bit is 1. Data bits that are 0 leave their flag unchanged.
- R4: If an event pulse and a clear of the same bit fall in the same cycle, the flag stays set.
- R5: Status bits 0 (receive packet), 1 (transmit space), 2 (duplex packet), 12 (transmit complete), 14:13 (receive FIFO level) and 15 (receive word not empty) always equal their live inputs. Clear writes do not change them.
- R6: Offset 0x10 is the enable register. Bits 10:0 can be written and read back. Bits 31:11 read as zero.
- R7: The interrupt is high exactly when status[10:0] AND enable[10:0] is non-zero. Status bit 11 never raises the interrupt.
- R8: Status at 0x14 is read-only, so writes to it have no effect. The clear register and unmapped offsets read as zero.
- R9: With `REG_IRQ`=1, the interrupt follows the same rule as R7 but one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| ev_pulse | input | 9 | Sticky event pulses, bit k sets status bit k+3 |
| lv_rx_pkt | input | 1 | Live: receive packet available |
| lv_tx_space | input | 1 | Live: transmit space available |
| lv_dpx_pkt | input | 1 | Live: duplex packet |
| lv_tx_done | input | 1 | Live: transmit complete |
| lv_rx_lvl | input | 2 | Live: receive FIFO level |
| lv_rx_word | input | 1 | Live: receive word not empty |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two copies with the default 8-bit offset bus and 32-bit data. One has `REG_IRQ`=0 and the other `REG_IRQ`=1. They share every input, so the registered variant's one-cycle lag can be compared directly against the combinational one. The status word is small, so the bench sweeps all 128 live-input patterns and every sticky bit individually through set, partial clear and full clear. It also walks each enable position on its own. That covers every bit of the masking AND and the suspend exclusion.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
   localparam int STS_W     = 16;
   localparam int EN_W      = 11;
   localparam int STICKY_LO = 3;
   localparam int STICKY_HI = 11;
   localparam int STICKY_N  = STICKY_HI - STICKY_LO + 1;

   typedef struct packed {
      logic       rx_word;
      logic [1:0] rx_lvl;
      logic       tx_done;
      logic       dpx_pkt;
      logic       tx_space;
      logic       rx_pkt;
   } live_t;
endpackage

// File: rtl/aud_irq_sticky.sv
module aud_irq_sticky #(
   parameter int N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       flag[i] <= 1'b0;
         else if (evt[i])  flag[i] <= 1'b1;
         else if (clr[i])  flag[i] <= 1'b0;
      end

      // R2 / R4: an event always leaves the flag set
      p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flag[i]);
      // R3: a clear without a competing event drops the flag
      p_clr_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !evt[i]) |=> !flag[i]);
      // R3: no event and no clear, flag holds
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr[i] && !evt[i]) |=> $stable(flag[i]));
   end
endmodule

// File: rtl/aud_irq_enable.sv
module aud_irq_enable #(
   parameter int W      = 11,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] OFS = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      en
);
   always_ff @(posedge clk) begin
      if (!rst_n)                   en <= '0;
      else if (wr && addr == OFS)   en <= wdata;
   end

   // R6: a write to the enable offset is visible the next cycle
   p_en_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == OFS) |=> (en == $past(wdata)));
endmodule

// File: rtl/aud_irq_rdmux.sv
module aud_irq_rdmux #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int EN_W   = 11,
   parameter int STS_W  = 16,
   parameter logic [ADDR_W-1:0] EN_OFS  = 'h10,
   parameter logic [ADDR_W-1:0] STS_OFS = 'h14
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [EN_W-1:0]   en,
   input  logic [STS_W-1:0]  sts,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (addr == EN_OFS)       rdata[EN_W-1:0]  = en;
      else if (addr == STS_OFS) rdata[STS_W-1:0] = sts;
   end
endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status
   import aud_irq_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter logic [ADDR_W-1:0] EN_OFS  = 'h10,
   parameter logic [ADDR_W-1:0] STS_OFS = 'h14,
   parameter logic [ADDR_W-1:0] CLR_OFS = 'h18,
   parameter bit   REG_IRQ = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [STICKY_N-1:0] ev_pulse,
   input  logic                lv_rx_pkt,
   input  logic                lv_tx_space,
   input  logic                lv_dpx_pkt,
   input  logic                lv_tx_done,
   input  logic [1:0]          lv_rx_lvl,
   input  logic                lv_rx_word,
   output logic                irq
);
   if (DATA_W < STS_W) begin : g_bad_data_w
      $error("DATA_W must hold the status word");
   end
   if (EN_OFS == STS_OFS || EN_OFS == CLR_OFS || STS_OFS == CLR_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end

   live_t                live;
   logic [STICKY_N-1:0]  clr_vec;
   logic [STICKY_N-1:0]  flag;
   logic [EN_W-1:0]      en;
   logic [STS_W-1:0]     sts;
   logic                 irq_raw;
   logic                 unused_wdata;

   assign live = '{rx_word: lv_rx_word, rx_lvl: lv_rx_lvl, tx_done: lv_tx_done,
                   dpx_pkt: lv_dpx_pkt, tx_space: lv_tx_space, rx_pkt: lv_rx_pkt};

   assign clr_vec      = (bus_wr && bus_addr == CLR_OFS) ? bus_wdata[STICKY_HI:STICKY_LO] : '0;
   assign unused_wdata = ^bus_wdata[DATA_W-1:STICKY_HI+1];

   aud_irq_sticky #(.N(STICKY_N)) sticky_i (
      .clk(clk), .rst_n(rst_n), .evt(ev_pulse), .clr(clr_vec), .flag(flag));

   aud_irq_enable #(.W(EN_W), .ADDR_W(ADDR_W), .OFS(EN_OFS)) enable_i (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata[EN_W-1:0]), .en(en));

   assign sts = {live.rx_word, live.rx_lvl, live.tx_done, flag,
                 live.dpx_pkt, live.tx_space, live.rx_pkt};

   aud_irq_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W), .STS_W(STS_W),
                   .EN_OFS(EN_OFS), .STS_OFS(STS_OFS)) rdmux_i (
      .addr(bus_addr), .en(en), .sts(sts), .rdata(bus_rdata));

   assign irq_raw = |(sts[EN_W-1:0] & en);

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
   end

   // R7: with nothing enabled no interrupt can arise
   p_no_irq_wo_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq_raw);
   // R7: the suspended flag alone never raises the interrupt
   p_susp_excluded_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts[EN_W-1:0] == '0 && sts[STICKY_HI]) |-> !irq_raw);
   // R8: the clear register reads as zero
   p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CLR_OFS) |-> (bus_rdata == '0));
endmodule

// File: tb/aud_irq_status_tb_top.sv
module aud_irq_status_tb_top;
   localparam logic [7:0] A_EN = 8'h10, A_STS = 8'h14, A_CLR = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, rdata_r;
   logic [8:0]  ev_pulse = '0;
   logic [6:0]  lv = '0;
   logic        irq, irq_r;

   int n_chk = 0;
   int n_err = 0;
   logic [8:0]  m_sticky = '0;
   logic [10:0] m_en = '0;

   always #4 clk = ~clk;

   aud_irq_status #(.REG_IRQ(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
      .lv_rx_pkt(lv[0]), .lv_tx_space(lv[1]), .lv_dpx_pkt(lv[2]),
      .lv_tx_done(lv[3]), .lv_rx_lvl(lv[5:4]), .lv_rx_word(lv[6]), .irq(irq));

   aud_irq_status #(.REG_IRQ(1'b1)) dut_r_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_r), .ev_pulse(ev_pulse),
      .lv_rx_pkt(lv[0]), .lv_tx_space(lv[1]), .lv_dpx_pkt(lv[2]),
      .lv_tx_done(lv[3]), .lv_rx_lvl(lv[5:4]), .lv_rx_word(lv[6]), .irq(irq_r));

   function automatic logic [31:0] exp_sts();
      return {16'h0, lv[6], lv[5:4], lv[3], m_sticky, lv[2:0]};
   endfunction

   function automatic logic exp_irq();
      logic [31:0] s;
      s = exp_sts();
      return |(s[10:0] & m_en);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic bwrite(logic [7:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(int k);
      ev_pulse = 9'(1 << k);
      step();
      ev_pulse = '0;
      m_sticky[k] = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      rd(A_STS, d); check("R1 status", d, 32'h0);
      rd(A_EN, d);  check("R1 enable", d, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 irq_r", {31'h0, irq_r}, 32'h0);

      // R5 live sweep over every pattern
      for (int p = 0; p < 128; p++) begin
         lv = 7'(p);
         rd(A_STS, d); check("R5 live", d, exp_sts());
      end
      lv = 7'h7F;
      bwrite(A_CLR, 32'hFFFF_FFFF);
      rd(A_STS, d); check("R5 live after clear", d, exp_sts());
      lv = '0;

      // R2 / R3 per sticky bit
      for (int k = 0; k < 9; k++) begin
         pulse(k);
         rd(A_STS, d); check("R2 set", d, exp_sts());
         step();
         rd(A_STS, d); check("R2 held", d, exp_sts());
         bwrite(A_CLR, ~(32'h1 << (k + 3)));
         rd(A_STS, d); check("R3 zero no effect", d, exp_sts());
         bwrite(A_CLR, 32'h1 << (k + 3));
         m_sticky[k] = 1'b0;
         rd(A_STS, d); check("R3 cleared", d, exp_sts());
      end

      // R4 event and clear in the same cycle
      pulse(2);
      ev_pulse = 9'h004;
      bwrite(A_CLR, 32'h0000_0020);
      ev_pulse = '0;
      rd(A_STS, d); check("R4 event wins", d, exp_sts());
      bwrite(A_CLR, 32'h0000_0FF8);
      m_sticky = '0;
      rd(A_STS, d); check("R3 clear all", d, exp_sts());

      // R6 enable register width
      bwrite(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, d); check("R6 enable readback", d, 32'h0000_07FF);
      bwrite(A_EN, 32'h0000_0555);
      rd(A_EN, d); check("R6 enable pattern", d, 32'h0000_0555);

      // R8 read-only and zero reads
      pulse(4);
      bwrite(A_STS, 32'h0000_0000);
      rd(A_STS, d); check("R8 status read-only", d, exp_sts());
      rd(A_CLR, d); check("R8 clear reads zero", d, 32'h0);
      rd(8'h00, d); check("R8 unmapped zero", d, 32'h0);
      bwrite(A_CLR, 32'h0000_0080);
      m_sticky = '0;
      bwrite(A_EN, 32'h0);
      m_en = '0;

      // R7 walk each enable position
      for (int k = 0; k < 11; k++) begin
         m_en = 11'(1 << k);
         bwrite(A_EN, {21'h0, m_en});
         check("R7 idle", {31'h0, irq}, 32'h0);
         if (k < 3) begin
            lv[k] = 1'b1; #1;
         end else begin
            pulse(k - 3);
         end
         check("R7 source on", {31'h0, irq}, {31'h0, exp_irq()});
         bwrite(A_EN, {21'h0, ~m_en});
         m_en = ~m_en;
         check("R7 other enables", {31'h0, irq}, {31'h0, exp_irq()});
         lv = '0;
         bwrite(A_CLR, 32'h0000_0FF8);
         m_sticky = '0;
         bwrite(A_EN, 32'h0);
         m_en = '0;
      end

      // R7 suspend excluded
      pulse(8);
      bwrite(A_EN, 32'hFFFF_FFFF);
      m_en = 11'h7FF;
      check("R7 suspend no irq", {31'h0, irq}, 32'h0);
      bwrite(A_CLR, 32'h0000_0800);
      m_sticky = '0;

      // R9 registered interrupt lags one cycle
      pulse(2);
      check("R9 comb high", {31'h0, irq}, 32'h1);
      check("R9 reg still low", {31'h0, irq_r}, 32'h0);
      step();
      check("R9 reg high", {31'h0, irq_r}, 32'h1);
      bwrite(A_CLR, 32'h0000_0020);
      m_sticky = '0;
      check("R9 comb low", {31'h0, irq}, 32'h0);
      check("R9 reg lag", {31'h0, irq_r}, 32'h1);
      step();
      check("R9 reg low", {31'h0, irq_r}, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule